// File: doc/BRIEF.md
# Per-Port Clear-on-Read MAC Statistics Bank

This block keeps the traffic statistics for the ports of an Ethernet switch. Each port's MAC datapath reports finished frames through a receive event and a transmit event. An event carries the frame length and a vector of classification flags. The bank sorts every event into event counters, length-size buckets and byte totals. Software reads the counters through a single-cycle read port.

Each port owns a window of 42 counter words in a common address space. The windows are 0x100 bytes apart, starting at a fixed base. A read returns the counter and clears it in the same access, so software sees the activity since its previous read. Byte totals are twice the counter width and occupy a low word and a high word. Reading the low word also captures the high word, so the pair can be read coherently. Counters stop at all-ones instead of wrapping. Software must still read them often enough that the saturated value is never reached in practice.

Top module: `stat_bank`

## Requirements
- R1: The window of port p (0..NUM_PORTS-1, default six ports) starts at BASE_ADDR + p*0x100 (default base 0x20000). Word offsets inside a window, each 4 bytes apart:
  - Receive side: 0x00 broadcast, 0x04 pause, 0x08 multicast, 0x0c FCS error, 0x10 alignment error, 0x14 runt, 0x18 fragment. Size buckets run from 0x1c to 0x34. Then 0x38 too-long, 0x3c/0x40 good bytes low/high, 0x44/0x48 bad bytes low/high, 0x4c overflow, 0x50 filtered.
  - Transmit side: 0x54 broadcast, 0x58 pause, 0x5c multicast, 0x60 underrun. Size buckets run from 0x64 to 0x7c. Then 0x80 oversize, 0x84/0x88 bytes low/high. Seven collision-related words follow, from 0x8c to 0xa4: collision, abort collision, multiple collision, single collision, excessive deferral, deferral, late collision.
  - After reset every counter reads zero.
- R2: `rd_valid` is high in the cycle after each cycle in which `rd_en` is high, and `rd_data` carries the value addressed in that earlier cycle. When `rd_valid` is low, `rd_data` is zero.
- R3: A read of any mapped word clears it. An immediate re-read of the same word returns zero if no event arrived in between.
- R4: If an event increments a counter in the same cycle that the counter is read, two things happen. The read returns the value from before the event, and the counter then holds exactly that event's increment, so the event is not lost.
- R5: A counted frame goes into exactly one size bucket. The buckets, in word order, are length <=64, <=128, <=256, <=512, <=1024, <=1518, and longer than 1518.
- R6: A byte total is 2*CNT_W bits wide.
  - Reading its low word returns the low half, captures the high half into a holding register and clears the whole total.
  - Reading the high word returns the holding register and then clears it. A high-word read that was not preceded by a low-word read returns whatever is held, which is zero if it has already been read.
- R7: Event counters saturate at 2^CNT_W-1 and byte totals saturate at 2^(2*CNT_W)-1; neither wraps.
- R8: Good and bad receive frames are counted differently.
  - A receive frame is bad if any of FCS error, alignment error, runt, fragment, too-long or overflow is flagged. A bad frame adds its length to the bad-byte total and enters no bucket. A good frame adds to the good-byte total and one receive bucket.
  - A transmit frame flagged underrun or abort-collision adds to neither the transmit byte total nor a bucket. Any other transmit frame adds to both.
- R9: Each flagged condition adds one to its own word.
  - Receive flag bits: 0 broadcast, 1 multicast, 2 pause, 3 FCS error, 4 alignment, 5 runt, 6 fragment, 7 too-long, 8 overflow, 9 filtered.
  - Transmit flag bits: 0 broadcast, 1 multicast, 2 pause, 3 underrun, 4 oversize, 5 collision, 6 abort collision, 7 multiple collision, 8 single collision, 9 excessive deferral, 10 deferral, 11 late collision.
- R10: A read that is misaligned, below the base, past word 41 of a window, or in a window beyond the last port returns zero and clears nothing.
- R11: Events on one port never change the counters of another port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | NUM_PORTS | Receive frame event, one bit per port |
| rx_len | input | NUM_PORTS*LEN_W | Receive frame length in bytes, per port |
| rx_flags | input | NUM_PORTS*10 | Receive classification flags per port (R9) |
| tx_vld | input | NUM_PORTS | Transmit frame event, one bit per port |
| tx_len | input | NUM_PORTS*LEN_W | Transmit frame length in bytes, per port |
| tx_flags | input | NUM_PORTS*12 | Transmit classification flags per port (R9) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of the word to read |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | CNT_W | Read result |

## Verification
The checker relies on `rd_en` being held low during reset, because one property compares each read with the read one cycle before. Its re-read property also assumes that a read which sees no event arriving on any port in the previous cycle observes a counter that nothing else touched. The stimulus keeps to this by driving events and reads only from a single procedural stream that starts after reset is released. Frame lengths stay below 2^LEN_W. The bench runs with 8-bit counters so that the saturation limits of both counter kinds are reachable in a short run.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int NWORDS    = 42;
    localparam int STRIDE_LG = 8;
    localparam int WORD_W    = STRIDE_LG - 2;
    localparam int RXF_W     = 10;
    localparam int TXF_W     = 12;
    localparam int NBUCKETS  = 7;

    typedef struct packed {
        logic filtered;
        logic overflow;
        logic too_long;
        logic fragment;
        logic runt;
        logic align_err;
        logic fcs_err;
        logic pause;
        logic mcast;
        logic bcast;
    } rx_flags_t;

    typedef struct packed {
        logic late_col;
        logic defer;
        logic exc_defer;
        logic single_col;
        logic multi_col;
        logic abort_col;
        logic collision;
        logic oversize;
        logic underrun;
        logic pause;
        logic mcast;
        logic bcast;
    } tx_flags_t;

    typedef enum logic [1:0] { K_EVENT, K_LO, K_HI } word_kind_e;

    // word indices within one port window
    localparam int W_RX_BCAST    = 0;
    localparam int W_RX_PAUSE    = 1;
    localparam int W_RX_MCAST    = 2;
    localparam int W_RX_FCS      = 3;
    localparam int W_RX_ALIGN    = 4;
    localparam int W_RX_RUNT     = 5;
    localparam int W_RX_FRAG     = 6;
    localparam int W_RX_BKT0     = 7;
    localparam int W_RX_TOOLONG  = 14;
    localparam int W_RX_GOOD_LO  = 15;
    localparam int W_RX_BAD_LO   = 17;
    localparam int W_RX_OVFL     = 19;
    localparam int W_RX_FILT     = 20;
    localparam int W_TX_BCAST    = 21;
    localparam int W_TX_PAUSE    = 22;
    localparam int W_TX_MCAST    = 23;
    localparam int W_TX_UNDER    = 24;
    localparam int W_TX_BKT0     = 25;
    localparam int W_TX_OVERSIZE = 32;
    localparam int W_TX_BYTE_LO  = 33;
    localparam int W_TX_COL      = 35;
    localparam int W_TX_ABORT    = 36;
    localparam int W_TX_MULTI    = 37;
    localparam int W_TX_SINGLE   = 38;
    localparam int W_TX_EXCDEF   = 39;
    localparam int W_TX_DEFER    = 40;
    localparam int W_TX_LATE     = 41;

    function automatic word_kind_e word_kind(input int w);
        if (w == W_RX_GOOD_LO || w == W_RX_BAD_LO || w == W_TX_BYTE_LO)
            return K_LO;
        if (w == W_RX_GOOD_LO + 1 || w == W_RX_BAD_LO + 1 || w == W_TX_BYTE_LO + 1)
            return K_HI;
        return K_EVENT;
    endfunction

    // first bucket whose upper bound covers the length
    function automatic logic [2:0] size_bucket(input logic [15:0] len);
        if (len <= 16'd64)        return 3'd0;
        else if (len <= 16'd128)  return 3'd1;
        else if (len <= 16'd256)  return 3'd2;
        else if (len <= 16'd512)  return 3'd3;
        else if (len <= 16'd1024) return 3'd4;
        else if (len <= 16'd1518) return 3'd5;
        else                      return 3'd6;
    endfunction

endpackage

// File: rtl/stat_cell.sv
module stat_cell #(
    parameter int W  = 32,
    parameter int AW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic [AW-1:0] amt,
    input  logic          clr,
    output logic [W-1:0]  val
);
    logic [W:0] sum;

    assign sum = {1'b0, val} + (W+1)'(amt);

    always_ff @(posedge clk) begin
        if (rst)
            val <= '0;
        else if (clr)
            val <= inc ? W'(amt) : '0;     // restart at the coincident increment
        else if (inc)
            val <= sum[W] ? '1 : sum[W-1:0];
    end
endmodule

// File: rtl/stat_port.sv
module stat_port
    import stat_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_vld,
    input  logic [LEN_W-1:0]  rx_len,
    input  rx_flags_t         rx_f,
    input  logic              tx_vld,
    input  logic [LEN_W-1:0]  tx_len,
    input  tx_flags_t         tx_f,
    input  logic              rd_sel,
    input  logic [WORD_W-1:0] rd_word,
    output logic [CNT_W-1:0]  rd_val
);
    logic [NWORDS-1:0]            ev;
    logic [NWORDS-1:0]            clr;
    logic [NWORDS-1:0][CNT_W-1:0] rdv;
    logic                         rx_good, tx_ok;
    logic [2:0]                   rxb, txb;

    always_comb begin
        rx_good = !(rx_f.fcs_err | rx_f.align_err | rx_f.runt | rx_f.fragment |
                    rx_f.too_long | rx_f.overflow);
        tx_ok   = !(tx_f.underrun | tx_f.abort_col);
        rxb     = size_bucket(16'(rx_len));
        txb     = size_bucket(16'(tx_len));

        ev = '0;
        ev[W_RX_BCAST]   = rx_vld & rx_f.bcast;
        ev[W_RX_PAUSE]   = rx_vld & rx_f.pause;
        ev[W_RX_MCAST]   = rx_vld & rx_f.mcast;
        ev[W_RX_FCS]     = rx_vld & rx_f.fcs_err;
        ev[W_RX_ALIGN]   = rx_vld & rx_f.align_err;
        ev[W_RX_RUNT]    = rx_vld & rx_f.runt;
        ev[W_RX_FRAG]    = rx_vld & rx_f.fragment;
        ev[W_RX_TOOLONG] = rx_vld & rx_f.too_long;
        ev[W_RX_OVFL]    = rx_vld & rx_f.overflow;
        ev[W_RX_FILT]    = rx_vld & rx_f.filtered;
        ev[W_RX_GOOD_LO] = rx_vld & rx_good;
        ev[W_RX_BAD_LO]  = rx_vld & !rx_good;
        ev[W_RX_BKT0 + int'(rxb)] = rx_vld & rx_good;

        ev[W_TX_BCAST]    = tx_vld & tx_f.bcast;
        ev[W_TX_PAUSE]    = tx_vld & tx_f.pause;
        ev[W_TX_MCAST]    = tx_vld & tx_f.mcast;
        ev[W_TX_UNDER]    = tx_vld & tx_f.underrun;
        ev[W_TX_OVERSIZE] = tx_vld & tx_f.oversize;
        ev[W_TX_COL]      = tx_vld & tx_f.collision;
        ev[W_TX_ABORT]    = tx_vld & tx_f.abort_col;
        ev[W_TX_MULTI]    = tx_vld & tx_f.multi_col;
        ev[W_TX_SINGLE]   = tx_vld & tx_f.single_col;
        ev[W_TX_EXCDEF]   = tx_vld & tx_f.exc_defer;
        ev[W_TX_DEFER]    = tx_vld & tx_f.defer;
        ev[W_TX_LATE]     = tx_vld & tx_f.late_col;
        ev[W_TX_BYTE_LO]  = tx_vld & tx_ok;
        ev[W_TX_BKT0 + int'(txb)] = tx_vld & tx_ok;

        clr = rd_sel ? (NWORDS'(1) << rd_word) : '0;
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        if (word_kind(w) == K_LO) begin : g_wide
            localparam bit IS_TX = (w >= W_TX_BCAST);
            logic [2*CNT_W-1:0] total;
            logic [CNT_W-1:0]   held_hi;
            logic [LEN_W-1:0]   amt_w;

            assign amt_w = IS_TX ? tx_len : rx_len;

            stat_cell #(.W(2*CNT_W), .AW(LEN_W)) u_cell (
                .clk (clk),
                .rst (rst),
                .inc (ev[w] | ev[w+1]),
                .amt (amt_w),
                .clr (clr[w]),
                .val (total)
            );

            always_ff @(posedge clk) begin
                if (rst)
                    held_hi <= '0;
                else if (clr[w])
                    held_hi <= total[2*CNT_W-1:CNT_W];
                else if (clr[w+1])
                    held_hi <= '0;
            end

            assign rdv[w]   = total[CNT_W-1:0];
            assign rdv[w+1] = held_hi;
        end else if (word_kind(w) == K_EVENT) begin : g_evt
            logic [CNT_W-1:0] cnt;

            stat_cell #(.W(CNT_W), .AW(1)) u_cell (
                .clk (clk),
                .rst (rst),
                .inc (ev[w]),
                .amt (1'b1),
                .clr (clr[w]),
                .val (cnt)
            );

            assign rdv[w] = cnt;
        end
    end

    assign rd_val = (int'(rd_word) < NWORDS) ? rdv[rd_word] : '0;
endmodule

// File: rtl/stat_bank.sv
module stat_bank
    import stat_pkg::*;
#(
    parameter int          NUM_PORTS = 6,
    parameter int          CNT_W     = 32,
    parameter int          LEN_W     = 14,
    parameter int          ADDR_W    = 18,
    parameter int unsigned BASE_ADDR = 32'h20000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PORTS-1:0]       rx_vld,
    input  logic [NUM_PORTS*LEN_W-1:0] rx_len,
    input  logic [NUM_PORTS*RXF_W-1:0] rx_flags,
    input  logic [NUM_PORTS-1:0]       tx_vld,
    input  logic [NUM_PORTS*LEN_W-1:0] tx_len,
    input  logic [NUM_PORTS*TXF_W-1:0] tx_flags,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic                       rd_valid,
    output logic [CNT_W-1:0]           rd_data
);
    localparam int PIDX_W = ADDR_W - STRIDE_LG;
    localparam logic [ADDR_W-1:0] BASE_L  = ADDR_W'(BASE_ADDR);
    localparam logic [PIDX_W-1:0] NPORT_L = PIDX_W'(NUM_PORTS);
    localparam logic [WORD_W-1:0] NWORD_L = WORD_W'(NWORDS);

    logic [ADDR_W-1:0]                off;
    logic [PIDX_W-1:0]                pidx;
    logic [WORD_W-1:0]                word;
    logic                             hit;
    logic [NUM_PORTS-1:0]             rd_sel;
    logic [NUM_PORTS-1:0][CNT_W-1:0]  pval;
    logic [CNT_W-1:0]                 sel_val;

    always_comb begin
        off  = rd_addr - BASE_L;
        pidx = off[ADDR_W-1:STRIDE_LG];
        word = off[STRIDE_LG-1:2];
        hit  = rd_en && (rd_addr >= BASE_L) && (off[1:0] == 2'b00) &&
               (pidx < NPORT_L) && (word < NWORD_L);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign rd_sel[p] = hit && (pidx == PIDX_W'(p));

        stat_port #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_port (
            .clk     (clk),
            .rst     (rst),
            .rx_vld  (rx_vld[p]),
            .rx_len  (rx_len[p*LEN_W +: LEN_W]),
            .rx_f    (rx_flags_t'(rx_flags[p*RXF_W +: RXF_W])),
            .tx_vld  (tx_vld[p]),
            .tx_len  (tx_len[p*LEN_W +: LEN_W]),
            .tx_f    (tx_flags_t'(tx_flags[p*TXF_W +: TXF_W])),
            .rd_sel  (rd_sel[p]),
            .rd_word (word),
            .rd_val  (pval[p])
        );
    end

    always_comb begin
        sel_val = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (rd_sel[p]) sel_val = pval[p];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= sel_val;
        end
    end
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
    parameter int NUM_PORTS = 6,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 18
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_PORTS-1:0] rx_vld,
    input logic [NUM_PORTS-1:0] tx_vld,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic                 rd_valid,
    input logic [CNT_W-1:0]     rd_data
);
    // R2: a read strobe yields a valid result one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R2: no strobe, no valid and a zero result
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && rd_data == '0));

    // R10: misaligned reads return zero
    a_r10_misaligned_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr[1:0] != 2'b00) |=> rd_data == '0);

    // R3: back-to-back reads of one word with no event in between see zero
    a_r3_reread_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en) && rd_addr == $past(rd_addr) &&
         $past(rx_vld) == '0 && $past(tx_vld) == '0) |=> rd_data == '0);
endmodule

bind stat_bank stat_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W)
) u_chk (.*);

// File: tb/tb_stat_bank.sv
module tb_stat_bank;
    localparam int NP   = 6;
    localparam int CW   = 8;
    localparam int LW   = 14;
    localparam int AW   = 18;
    localparam int unsigned BASE = 32'h20000;
    localparam int unsigned NMAX = (1 << CW) - 1;
    localparam int unsigned WMAX = (1 << (2*CW)) - 1;
    localparam int NW   = 42;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NP-1:0]    rx_vld = '0;
    logic [NP*LW-1:0] rx_len = '0;
    logic [NP*10-1:0] rx_flags = '0;
    logic [NP-1:0]    tx_vld = '0;
    logic [NP*LW-1:0] tx_len = '0;
    logic [NP*12-1:0] tx_flags = '0;
    logic             rd_en = 1'b0;
    logic [AW-1:0]    rd_addr = '0;
    logic             rd_valid;
    logic [CW-1:0]    rd_data;

    int checks = 0;
    int fails  = 0;
    int unsigned m  [NP][NW];
    int unsigned sh [NP][NW];

    // flag bit -> word index, from the requirement tables
    int rx_map [10] = '{0, 2, 1, 3, 4, 5, 6, 14, 19, 20};
    int tx_map [12] = '{21, 23, 22, 24, 32, 35, 36, 37, 38, 39, 40, 41};

    always #5 clk = ~clk;

    stat_bank #(.NUM_PORTS(NP), .CNT_W(CW), .LEN_W(LW), .ADDR_W(AW),
                .BASE_ADDR(BASE)) dut (.*);

    function automatic bit is_lo(int w);
        return w == 15 || w == 17 || w == 33;
    endfunction
    function automatic bit is_hi(int w);
        return w == 16 || w == 18 || w == 34;
    endfunction
    function automatic int bucket(int unsigned len);
        int unsigned lim [6] = '{64, 128, 256, 512, 1024, 1518};
        for (int i = 0; i < 6; i++) if (len <= lim[i]) return i;
        return 6;
    endfunction
    function automatic int unsigned addr_of(int p, int w);
        return BASE + p * 256 + w * 4;
    endfunction

    function automatic void bump(int p, int w, int unsigned amt);
        if (is_lo(w)) m[p][w] = (m[p][w] + amt > WMAX) ? WMAX : m[p][w] + amt;
        else          m[p][w] = (m[p][w] + 1 > NMAX) ? NMAX : m[p][w] + 1;
    endfunction

    function automatic void mdl_rx(int p, int unsigned len, int unsigned fl);
        for (int i = 0; i < 10; i++) if (fl[i]) bump(p, rx_map[i], 1);
        if ((fl & 32'h1F8) == 0) begin
            bump(p, 7 + bucket(len), 1);
            bump(p, 15, len);
        end else begin
            bump(p, 17, len);
        end
    endfunction

    function automatic void mdl_tx(int p, int unsigned len, int unsigned fl);
        for (int i = 0; i < 12; i++) if (fl[i]) bump(p, tx_map[i], 1);
        if ((fl & 32'h48) == 0) begin
            bump(p, 25 + bucket(len), 1);
            bump(p, 33, len);
        end
    endfunction

    task automatic chk(input int unsigned act, input int unsigned exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: optional read, optional rx event, optional tx event
    task automatic step(input bit rd, input int unsigned addr, input string tag,
                        input int rp, input int unsigned rl, input int unsigned rf,
                        input int tp, input int unsigned tl, input int unsigned tf);
        int unsigned expv = 0;
        if (rd && addr >= BASE && (addr % 4) == 0) begin
            int pp = int'((addr - BASE) / 256);
            int ww = int'(((addr - BASE) % 256) / 4);
            if (pp < NP && ww < NW) begin
                if (is_lo(ww)) begin
                    expv = m[pp][ww] & NMAX;
                    sh[pp][ww+1] = m[pp][ww] >> CW;
                    m[pp][ww] = 0;
                end else if (is_hi(ww)) begin
                    expv = sh[pp][ww];
                    sh[pp][ww] = 0;
                end else begin
                    expv = m[pp][ww];
                    m[pp][ww] = 0;
                end
            end
        end
        if (rp >= 0) mdl_rx(rp, rl, rf);
        if (tp >= 0) mdl_tx(tp, tl, tf);
        rd_en   = rd;
        rd_addr = addr[AW-1:0];
        if (rp >= 0) begin
            rx_vld[rp] = 1'b1;
            rx_len[rp*LW +: LW] = rl[LW-1:0];
            rx_flags[rp*10 +: 10] = rf[9:0];
        end
        if (tp >= 0) begin
            tx_vld[tp] = 1'b1;
            tx_len[tp*LW +: LW] = tl[LW-1:0];
            tx_flags[tp*12 +: 12] = tf[11:0];
        end
        @(negedge clk);
        rd_en  = 1'b0;
        rx_vld = '0;
        tx_vld = '0;
        if (rd) begin
            chk(rd_valid, 1, {tag, " R2 valid"});
            chk(rd_data, expv, tag);
        end
    endtask

    task automatic rd(input int unsigned addr, input string tag);
        step(1, addr, tag, -1, 0, 0, -1, 0, 0);
    endtask
    task automatic rx(input int p, input int unsigned len, input int unsigned fl);
        step(0, 0, "", p, len, fl, -1, 0, 0);
    endtask
    task automatic tx(input int p, input int unsigned len, input int unsigned fl);
        step(0, 0, "", -1, 0, 0, p, len, fl);
    endtask
    task automatic read_all(input int p, input string tag);
        for (int w = 0; w < NW; w++) rd(addr_of(p, w), tag);
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned lens [14] = '{1, 64, 65, 128, 129, 256, 257, 512, 513,
                                   1024, 1025, 1518, 1519, 9000};
        for (int p = 0; p < NP; p++)
            for (int w = 0; w < NW; w++) begin m[p][w] = 0; sh[p][w] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 / R1: reset state
        chk(rd_valid, 0, "R2 reset valid");
        chk(rd_data, 0, "R2 reset data");
        for (int p = 0; p < NP; p++) rd(addr_of(p, p * 7), "R1 reset zero");

        // R5 R8: bucket boundaries, rx on port 0 and tx on port 1
        foreach (lens[i]) begin
            step(0, 0, "", 0, lens[i], 0, 1, lens[i], 0);
            read_all(0, "R5 R8 rx");
            read_all(1, "R5 R8 tx");
        end

        // R9 R1: every flag alone, rx on port 2 and tx on port 3
        for (int i = 0; i < 10; i++) rx(2, 100 + i, 1 << i);
        for (int i = 0; i < 12; i++) tx(3, 700 + i, 1 << i);
        rx(2, 60, 32'h3FF);
        tx(3, 1600, 32'h048);
        read_all(2, "R9 R1 rx");
        read_all(3, "R9 R1 tx");

        // R3: a second pass finds everything cleared
        read_all(2, "R3 reread");
        rd(addr_of(3, 33), "R3 lo twice");
        rd(addr_of(3, 33), "R3 lo twice");

        // R4: read and increment collide
        repeat (3) rx(4, 80, 1);
        step(1, addr_of(4, 0), "R4 old value", 4, 80, 1, -1, 0, 0);
        rd(addr_of(4, 0), "R4 restart");
        repeat (2) tx(4, 300, 32'h020);
        step(1, addr_of(4, 35), "R4 tx old", -1, 0, 0, 4, 300, 32'h020);
        rd(addr_of(4, 35), "R4 tx restart");

        // R6: split byte totals and the held high word
        read_all(4, "R6 flush");
        repeat (3) rx(4, 1000, 0);
        step(1, addr_of(4, 15), "R6 lo with event", 4, 200, 0, -1, 0, 0);
        rd(addr_of(4, 16), "R6 held hi");
        rd(addr_of(4, 16), "R6 hi cleared");
        rd(addr_of(4, 15), "R6 lo after event");
        rd(addr_of(4, 16), "R6 hi after event");
        rx(4, 600, 0);
        rd(addr_of(4, 16), "R6 hi without lo");
        rd(addr_of(4, 15), "R6 lo");
        rd(addr_of(4, 16), "R6 hi");
        repeat (2) rx(4, 900, 32'h008);
        rd(addr_of(4, 17), "R6 bad lo");
        rd(addr_of(4, 18), "R6 bad hi");
        repeat (2) tx(4, 1300, 0);
        rd(addr_of(4, 33), "R6 tx lo");
        rd(addr_of(4, 34), "R6 tx hi");

        // R7: saturation of both counter kinds
        repeat (300) rx(5, 64, 1);
        rd(addr_of(5, 0), "R7 event saturate");
        repeat (50) rx(5, 1518, 0);
        rd(addr_of(5, 12), "R7 bucket");
        rd(addr_of(5, 15), "R7 wide lo");
        rd(addr_of(5, 16), "R7 wide hi");
        repeat (260) tx(5, 64, 32'h004);
        rd(addr_of(5, 22), "R7 tx saturate");
        rd(addr_of(5, 22), "R7 after clear");

        // R10: unmapped and misaligned reads
        repeat (2) rx(0, 64, 1);
        rd(addr_of(0, 0) + 1, "R10 misaligned");
        rd(addr_of(0, 0) + 2, "R10 misaligned");
        rd(addr_of(0, 42), "R10 past last word");
        rd(addr_of(0, 63), "R10 past last word");
        rd(addr_of(NP, 0), "R10 no such port");
        rd(BASE - 4, "R10 below base");
        rd(addr_of(0, 0), "R10 untouched");

        // R11: one port active, all ports read
        for (int i = 0; i < 5; i++) step(0, 0, "", 1, 70 + 300 * i, 32'h003,
                                         1, 90 + 200 * i, 32'h120);
        for (int p = 0; p < NP; p++) read_all(p, "R11 isolation");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule